// File: doc/BRIEF.md
# Zero-Turnaround Synchronous Burst SRAM

A single-port synchronous SRAM whose bus can change from read to write, or from write to read, on consecutive clock cycles with no idle cycle between them. All controls are registered on the rising clock edge. A read returns its data on the bus two enabled cycles after its address. A write takes its data from the bus two enabled cycles after its address. Both directions therefore use the same bus slot, and writes are committed late through a two-stage address/control pipeline. A read that hits a write still in that pipeline gets the pending bytes merged with the stored word.

Each access begins with a load, which captures a new address. The advance control then steps a 2-bit burst counter through the other three words of the aligned group of four. The order is either interleaved (XOR) or linear (add, wrapping within four), and is chosen at load time. A clock-stall input freezes every register. Three chip selects qualify each load. The shared bus is modelled as separate `din` and `dout` ports plus an output enable.

Depth is `2**ADDR_W` words. `ADDR_W = 16` gives the full 65,536 x 32 array; the default is smaller so that elaboration stays light.

Controller states:
- `ST_IDLE`: deselected, no burst.
- `ST_READ`: a read burst is in progress.
- `ST_WRITE`: a write burst is in progress.

Transitions, all taken only on a non-stalled edge:
- A load with all three selects asserted goes to `ST_READ` when `rd_wr_n=1` and to `ST_WRITE` when `rd_wr_n=0`, from any state.
- A load with any select deasserted goes to `ST_IDLE` from any state.
- An advance keeps the current state.

Top module: `zt_sram`

## Requirements
- R1: A word written to any address in `0 .. 2**ADDR_W-1` reads back unchanged until it is overwritten.
- R2: Read data appears on `dout` with `dout_oe=1` in the bus cycle two enabled edges after the edge that captured the read address. `dout_oe` is 0 in every other cycle, including the cycles of writes and deselects.
- R3: Write data is sampled from `din` at the second enabled edge after the edge that captured the write address. `din` at any other edge has no effect.
- R4: `bw_n[i]` is active low and guards bits `8*i+7 : 8*i`. Lane 0 is bits 7:0 and lane 3 is bits 31:24. A lane whose bit is 1 keeps its stored byte. `bw_n=4'b0000` writes the whole word.
- R5: While `stall=1`, every input is ignored and all state holds: the pipeline, the burst counter, `dout` and `dout_oe`.
- R6: With interleaved order (`burst_lin=0` at the load), the k-th word of a burst (k=0..3) is at low address bits `base[1:0] XOR k`. The upper address bits are unchanged.
- R7: With linear order (`burst_lin=1` at the load), the k-th word is at `(base[1:0] + k) mod 4`. The order is latched at the load, and `burst_lin` during an advance is ignored. Interleaved order is in force after reset.
- R8: A load starts an access only when `sel_a_n=0`, `sel_b=1` and `sel_c_n=0`. Any other combination makes a deselect cycle: no write occurs and no read data is driven. An advance after a deselect is also a deselect.
- R9: Reads and writes may alternate on every cycle with no idle cycle, and each keeps its R2/R3 timing.
- R10: A read of an address whose write is still pending returns the pending write's enabled bytes merged with the stored bytes of the other lanes.
- R11: After reset, `dout_oe=0` and `dout=0`.
- R12: An advance continues the direction of the last load. After the fourth word of a burst, further advances wrap the counter through the same four addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall | input | 1 | 1 freezes all state and ignores all inputs |
| sel_a_n | input | 1 | Chip select A, active low |
| sel_b | input | 1 | Chip select B, active high |
| sel_c_n | input | 1 | Chip select C, active low |
| rd_wr_n | input | 1 | At a load: 1 read, 0 write |
| adv | input | 1 | 1 advances the burst counter, 0 loads `addr` |
| burst_lin | input | 1 | At a load: 1 linear order, 0 interleaved order |
| addr | input | ADDR_W | Word address |
| bw_n | input | DATA_W/8 | Byte-lane write enables, active low |
| din | input | DATA_W | Write data bus |
| dout | output | DATA_W | Read data bus |
| dout_oe | output | 1 | Drive enable for `dout` |

## Verification
The address and control of an access are captured at an enabled edge E0. Read data is registered at E1 and is checked on the following falling edge. The write data driven before E2 is committed at E2. Stalled edges do not count toward these two edges, and the bench's model advances its own two-entry pipeline only on edges it drove without `stall`. Every output is sampled at the falling edge after the rising edge that updates it. For the pending-write case, the merged value is predicted from the `din` the bench is driving in that same cycle.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } zt_state_e;

    // Low two address bits of the k-th word of a burst.
    function automatic logic [1:0] zt_burst_idx(input logic [1:0] base,
                                                input logic [1:0] k,
                                                input logic       lin);
        return lin ? (base + k) : (base ^ k);
    endfunction

endpackage

// File: rtl/zt_sram_ctl.sv
module zt_sram_ctl
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              adv,
    input  logic              sel_ok,
    input  logic              rd_wr_n,
    input  logic              burst_lin,
    input  logic [ADDR_W-1:0] addr,
    output logic              iss_v,
    output logic              iss_w,
    output logic [ADDR_W-1:0] iss_addr
);

    zt_state_e         state, state_nx;
    logic [ADDR_W-1:0] base_q;
    logic [1:0]        cnt_q;
    logic              lin_q;

    // State register, burst base, order and counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            base_q <= '0;
            cnt_q  <= '0;
            lin_q  <= 1'b0;
        end else if (!stall) begin
            state <= state_nx;
            if (!adv) begin
                base_q <= addr;
                cnt_q  <= '0;
                lin_q  <= burst_lin;
            end else if (state != ST_IDLE) begin
                cnt_q <= cnt_q + 2'd1;
            end
        end
    end

    // Next state and the access issued at this edge
    always_comb begin
        state_nx = state;
        iss_v    = 1'b0;
        iss_w    = 1'b0;
        iss_addr = addr;
        unique case (state)
            ST_IDLE, ST_READ, ST_WRITE: begin
                if (!adv) begin
                    state_nx = !sel_ok ? ST_IDLE : (rd_wr_n ? ST_READ : ST_WRITE);
                    iss_v    = sel_ok;
                    iss_w    = !rd_wr_n;
                    iss_addr = addr;
                end else begin
                    state_nx = state;
                    iss_v    = (state != ST_IDLE);
                    iss_w    = (state == ST_WRITE);
                    iss_addr = {base_q[ADDR_W-1:2],
                                zt_burst_idx(base_q[1:0], cnt_q + 2'd1, lin_q)};
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/zt_sram_pipe.sv
module zt_sram_pipe #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              in_v,
    input  logic              in_w,
    input  logic [ADDR_W-1:0] in_a,
    input  logic [LANES-1:0]  in_bw_n,
    output logic              s1_v,
    output logic              s1_w,
    output logic [ADDR_W-1:0] s1_a,
    output logic              s2_v,
    output logic              s2_w,
    output logic [ADDR_W-1:0] s2_a,
    output logic [LANES-1:0]  s2_bw_n
);

    logic              v_q  [DEPTH];
    logic              w_q  [DEPTH];
    logic [ADDR_W-1:0] a_q  [DEPTH];
    logic [LANES-1:0]  bw_q [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q[s]  <= 1'b0;
                w_q[s]  <= 1'b0;
                a_q[s]  <= '0;
                bw_q[s] <= '1;
            end else if (!stall) begin
                if (s == 0) begin
                    v_q[s]  <= in_v;
                    w_q[s]  <= in_w;
                    a_q[s]  <= in_a;
                    bw_q[s] <= in_bw_n;
                end else begin
                    v_q[s]  <= v_q[s-1];
                    w_q[s]  <= w_q[s-1];
                    a_q[s]  <= a_q[s-1];
                    bw_q[s] <= bw_q[s-1];
                end
            end
        end
    end

    assign s1_v    = v_q[0];
    assign s1_w    = w_q[0];
    assign s1_a    = a_q[0];
    assign s2_v    = v_q[DEPTH-1];
    assign s2_w    = w_q[DEPTH-1];
    assign s2_a    = a_q[DEPTH-1];
    assign s2_bw_n = bw_q[DEPTH-1];

endmodule

// File: rtl/zt_sram_core.sv
module zt_sram_core #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stall,
    input  logic                s1_v,
    input  logic                s1_w,
    input  logic [ADDR_W-1:0]   s1_a,
    input  logic                s2_v,
    input  logic                s2_w,
    input  logic [ADDR_W-1:0]   s2_a,
    input  logic [DATA_W/8-1:0] s2_bw_n,
    input  logic [DATA_W-1:0]   din,
    output logic [DATA_W-1:0]   dout,
    output logic                dout_oe
);

    localparam int LANES = DATA_W / 8;
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [WORDS];
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] merged;
    logic              commit;

    assign commit  = !stall && s2_v && s2_w;
    assign rd_word = mem[s1_a];

    // Late write: data arrives on the bus two enabled cycles after its address
    always_ff @(posedge clk) begin
        if (commit) begin
            for (int l = 0; l < LANES; l++) begin
                if (!s2_bw_n[l]) mem[s2_a][l*8 +: 8] <= din[l*8 +: 8];
            end
        end
    end

    // Pending-write bypass, lane by lane
    always_comb begin
        merged = rd_word;
        for (int l = 0; l < LANES; l++) begin
            if (s2_v && s2_w && (s2_a == s1_a) && !s2_bw_n[l])
                merged[l*8 +: 8] = din[l*8 +: 8];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout    <= '0;
            dout_oe <= 1'b0;
        end else if (!stall) begin
            dout_oe <= s1_v && !s1_w;
            if (s1_v && !s1_w) dout <= merged;
        end
    end

endmodule

// File: rtl/zt_sram.sv
module zt_sram #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stall,
    input  logic                sel_a_n,
    input  logic                sel_b,
    input  logic                sel_c_n,
    input  logic                rd_wr_n,
    input  logic                adv,
    input  logic                burst_lin,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W/8-1:0] bw_n,
    input  logic [DATA_W-1:0]   din,
    output logic [DATA_W-1:0]   dout,
    output logic                dout_oe
);

    localparam int LANES = DATA_W / 8;

    logic              sel_ok;
    logic              iss_v, iss_w;
    logic [ADDR_W-1:0] iss_addr;
    logic              s1_v, s1_w, s2_v, s2_w;
    logic [ADDR_W-1:0] s1_a, s2_a;
    logic [LANES-1:0]  s2_bw_n;

    assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

    zt_sram_ctl #(.ADDR_W(ADDR_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .stall(stall), .adv(adv), .sel_ok(sel_ok),
        .rd_wr_n(rd_wr_n), .burst_lin(burst_lin), .addr(addr),
        .iss_v(iss_v), .iss_w(iss_w), .iss_addr(iss_addr)
    );

    zt_sram_pipe #(.ADDR_W(ADDR_W), .LANES(LANES), .DEPTH(2)) u_pipe (
        .clk(clk), .rst_n(rst_n), .stall(stall),
        .in_v(iss_v), .in_w(iss_w), .in_a(iss_addr), .in_bw_n(bw_n),
        .s1_v(s1_v), .s1_w(s1_w), .s1_a(s1_a),
        .s2_v(s2_v), .s2_w(s2_w), .s2_a(s2_a), .s2_bw_n(s2_bw_n)
    );

    zt_sram_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_core (
        .clk(clk), .rst_n(rst_n), .stall(stall),
        .s1_v(s1_v), .s1_w(s1_w), .s1_a(s1_a),
        .s2_v(s2_v), .s2_w(s2_w), .s2_a(s2_a), .s2_bw_n(s2_bw_n),
        .din(din), .dout(dout), .dout_oe(dout_oe)
    );

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stall,
    input logic              adv,
    input logic              sel_a_n,
    input logic              sel_b,
    input logic              sel_c_n,
    input logic              s1_v,
    input logic              s1_w,
    input logic [DATA_W-1:0] dout,
    input logic              dout_oe
);

    AST_STALL_HOLDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(dout) && $stable(dout_oe)));                      // R5

    AST_READ_DRIVES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && s1_v && !s1_w) |=> dout_oe);                               // R2

    AST_QUIET_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !(s1_v && !s1_w)) |=> !dout_oe);                           // R2

    AST_DESELECT_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !adv && !(!sel_a_n && sel_b && !sel_c_n)) |=> !s1_v);     // R8

    AST_BURST_KEEPS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && adv && s1_v) |=> (s1_v && (s1_w == $past(s1_w))));        // R12

endmodule

bind zt_sram zt_sram_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .stall(stall), .adv(adv),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .s1_v(s1_v), .s1_w(s1_w), .dout(dout), .dout_oe(dout_oe)
);

// File: tb/test_zt_sram.sv
module test_zt_sram;

    localparam int AW    = 10;
    localparam int DW    = 32;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stall = 1'b0, sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
    logic          rd_wr_n = 1'b1, adv = 1'b0, burst_lin = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [3:0]    bw_n = '1;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_oe;

    int tests = 0, fails = 0;
    bit done = 0;

    zt_sram #(.ADDR_W(AW), .DATA_W(DW)) i_zt_sram (
        .clk(clk), .rst_n(rst_n), .stall(stall), .sel_a_n(sel_a_n), .sel_b(sel_b),
        .sel_c_n(sel_c_n), .rd_wr_n(rd_wr_n), .adv(adv), .burst_lin(burst_lin),
        .addr(addr), .bw_n(bw_n), .din(din), .dout(dout), .dout_oe(dout_oe)
    );

    always #5 clk = ~clk;

    // Reference model built from the requirements
    logic [DW-1:0] mm [WORDS];
    int            mst = 0;            // 0 deselected, 1 read burst, 2 write burst
    logic [AW-1:0] mbase = '0;
    logic [1:0]    mcnt = '0;
    bit            mlin = 0;
    bit            m1v = 0, m1w = 0, m2v = 0, m2w = 0;
    logic [AW-1:0] m1a = '0, m2a = '0;
    logic [3:0]    m1b = '1, m2b = '1;
    bit            e_oe = 0;
    logic [DW-1:0] e_dout = '0;

    function automatic logic [1:0] order(logic [1:0] b, logic [1:0] k, bit lin);
        return lin ? 2'(b + k) : (b ^ k);
    endfunction

    task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(bit st, bit ad, bit sa_n, bit sb, bit sc_n, bit rw, bit lin,
                        logic [AW-1:0] a, logic [3:0] bw, string tag);
        bit            iv, iw;
        logic [AW-1:0] ia;
        int            nst;
        stall = st; adv = ad; sel_a_n = sa_n; sel_b = sb; sel_c_n = sc_n;
        rd_wr_n = rw; burst_lin = lin; addr = a; bw_n = bw; din = $urandom;
        nst = mst;
        if (!ad) begin
            iv = !sa_n && sb && !sc_n; iw = !rw; ia = a;
            nst = !iv ? 0 : (rw ? 1 : 2);
        end else begin
            iv = (mst != 0); iw = (mst == 2);
            ia = {mbase[AW-1:2], order(mbase[1:0], 2'(mcnt + 2'd1), mlin)};
        end
        @(posedge clk);
        @(negedge clk);
        if (!st) begin
            e_oe = m1v && !m1w;
            if (e_oe) begin
                e_dout = mm[m1a];
                for (int l = 0; l < 4; l++)
                    if (m2v && m2w && m2a == m1a && !m2b[l]) e_dout[l*8 +: 8] = din[l*8 +: 8];
            end
            if (m2v && m2w)
                for (int l = 0; l < 4; l++)
                    if (!m2b[l]) mm[m2a][l*8 +: 8] = din[l*8 +: 8];
            m2v = m1v; m2w = m1w; m2a = m1a; m2b = m1b;
            m1v = iv;  m1w = iw;  m1a = ia;  m1b = bw;
            if (!ad) begin mbase = a; mcnt = 0; mlin = lin; end
            else if (mst != 0) mcnt = mcnt + 2'd1;
            mst = nst;
        end
        chk(dout_oe == e_oe, {tag, " oe"}, {31'd0, dout_oe}, {31'd0, e_oe});
        if (e_oe) chk(dout == e_dout, {tag, " data"}, dout, e_dout);
    endtask

    task automatic load(bit rw, logic [AW-1:0] a, bit lin, logic [3:0] bw, string tag);
        step(0, 0, 0, 1, 0, rw, lin, a, bw, tag);
    endtask

    task automatic advance(logic [3:0] bw, string tag);
        step(0, 1, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
             AW'($urandom), bw, tag);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) step(0, 0, 1, 1, 0, 1, 0, AW'($urandom), '1, tag);
    endtask

    initial begin
        void'($urandom(32'h5A17));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        chk(dout_oe == 1'b0, "R11 oe", {31'd0, dout_oe}, '0);
        chk(dout == '0, "R11 dout", dout, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: fill the array with write bursts, order chosen at random
        for (int b = 0; b < WORDS / 4; b++) begin
            load(0, AW'(b * 4), 1'($urandom), 4'b0000, "R1");
            for (int k = 0; k < 3; k++) advance(4'b0000, "R1");
        end
        idle(2, "R1");

        // R6: interleaved read burst from low bits 2 (2,3,0,1)
        load(1, AW'(12'h026), 0, '1, "R6");
        for (int k = 0; k < 3; k++) advance('1, "R6");
        idle(2, "R6");

        // R7: linear read burst from low bits 3, burst_lin toggled during advance
        load(1, AW'(12'h047), 1, '1, "R7");
        for (int k = 0; k < 3; k++) step(0, 1, 0, 1, 0, 1, 0, '0, '1, "R7");
        idle(2, "R7");

        // R12: write burst wrapping past four words, then read back
        load(0, AW'(12'h081), 1, 4'b0000, "R12");
        for (int k = 0; k < 5; k++) advance(4'b0000, "R12");
        load(1, AW'(12'h080), 0, '1, "R12");
        for (int k = 0; k < 3; k++) advance('1, "R12");
        idle(2, "R12");

        // R4 and R10: partial write followed at once by a read of the same word
        load(0, AW'(12'h100), 0, 4'b0000, "R4");
        load(0, AW'(12'h100), 0, 4'b1010, "R4");
        load(1, AW'(12'h100), 0, '1, "R10");
        load(0, AW'(12'h100), 0, 4'b0110, "R10");
        load(1, AW'(12'h100), 0, '1, "R10");
        idle(3, "R4");
        load(1, AW'(12'h100), 0, '1, "R4");
        idle(2, "R4");

        // R9: read/write alternating every cycle
        for (int i = 0; i < 8; i++) load(1'(i % 2), AW'(12'h200 + i), 0, 4'b0000, "R9");
        for (int i = 0; i < 8; i++) load(1, AW'(12'h200 + i), 0, '1, "R9");
        idle(2, "R9");

        // R8: each select off in turn during a write, then advance after a deselect
        step(0, 0, 1, 1, 0, 0, 0, AW'(12'h300), 4'b0000, "R8");
        step(0, 0, 0, 0, 0, 0, 0, AW'(12'h300), 4'b0000, "R8");
        step(0, 0, 0, 1, 1, 0, 0, AW'(12'h300), 4'b0000, "R8");
        advance(4'b0000, "R8");
        advance(4'b0000, "R8");
        idle(1, "R8");
        load(1, AW'(12'h300), 0, '1, "R8");
        idle(2, "R8");

        // R5 and R3: stalls across a write and a read, din changing while stalled
        load(0, AW'(12'h311), 0, 4'b0000, "R3");
        step(1, 0, 0, 1, 0, 1, 1, AW'($urandom), 4'b0000, "R5");
        load(1, AW'(12'h311), 0, '1, "R3");
        step(1, 0, 0, 1, 0, 0, 0, AW'($urandom), 4'b0000, "R5");
        step(1, 1, 0, 1, 0, 0, 0, AW'($urandom), 4'b0000, "R5");
        idle(1, "R3");
        step(1, 0, 0, 1, 0, 0, 0, AW'($urandom), 4'b0000, "R5");
        idle(2, "R5");
        load(1, AW'(12'h311), 0, '1, "R3");
        idle(2, "R3");

        // Constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom_range(99);
            bit st = (r < 8);
            bit ad = ($urandom_range(99) < 40);
            bit so = ($urandom_range(99) < 90);
            step(st, ad, so ? 1'b0 : 1'($urandom), so ? 1'b1 : 1'b0, so ? 1'b0 : 1'($urandom),
                 1'($urandom), 1'($urandom), AW'($urandom), 4'($urandom), "R9");
        end
        idle(3, "R1");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        done = 1;
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule